// File: doc/BRIEF.md
# Debug System Bus Access Master

This block lets an external debugger reach system memory without the help of a processor. The debugger reads and writes a small set of 32-bit registers through a simple single-cycle register port: a control/status word, the address words and the data words. The block turns those accesses into single requests on a generic request/grant/response bus. The request stays raised until it is granted. The block counts as busy from the cycle after the request is issued until the response arrives.

Only the lowest data word has side effects. Writing it stores the word and starts a bus write of the whole data register. Reading it returns the word, marks the data stale, and can step the address and start the next bus read. A debugger can therefore stream memory by reading one register over and over. Misuse never corrupts state. A busy violation, a read of stale data, an unsupported access size or a bus error each record a sticky error code. While that code is set, the data registers ignore every access.

Top module: `sba_master`

## Requirements
- R1: After reset, the control word (index 0) reads 0x00000002: access size 2 in bits 2:0, auto-increment (bit 3) off, auto-read (bit 4) off, error code (bits 10:8) 0, busy (bit 12) 0, stale (bit 16) 0. The address and data registers are zero and no bus request is raised.
- R2: A write of data word 0 (index 4) with no error, not busy and a supported size raises bus_req_o on the next cycle. The request carries bus_we_o=1, the current address, the programmed size, and the data register with the written word in bits 31:0. The request holds steady until granted, and busy reads 1 until the response arrives.
- R3: With auto-increment on, each bus access started from data word 0 adds 2^size bytes to the address. For a write, the access uses the old address. For a read, the address steps first.
- R4: A read of data word 0 with no error, not busy and not stale returns the word and sets stale. With auto-read on and a supported size, it issues a bus read (bus_we_o=0). An accepted write of data word 0 clears stale.
- R5: A read of data word 0 while stale or busy sets error code 4. It starts no bus access and leaves the address unchanged.
- R6: A response without error to a bus read loads the full data register from bus_rsp_rdata_i and clears stale.
- R7: A response with bus_rsp_err_i set sets error code 2 and leaves the data register unchanged.
- R8: Size codes 0 to 4 select 8, 16, 32, 64 and 128 bits. A size is supported only up to DATA_W. Starting an access with an unsupported size sets error code 3, issues no bus access and does not step the address.
- R9: A write of the control word, an address word (indices 1 to 3, for address bits 31:0, 63:32 and 95:64) or a data word while busy sets error code 4. The written register keeps its value.
- R10: While the error code is nonzero, accesses to data words (indices 4 to 7) have no effect: no store, no stale change, no bus access.
- R11: The error code is sticky: a later error does not replace it. Writing 1s to bits 10:8 of the control word clears the matching bits.
- R12: Data words 1 to 3 (indices 5 to 7) store and return their value with no side effects. They form bits 63:32 upward of a wide bus write.
- R13: Each address word reads back its 32-bit slice of the address. Words beyond ADDR_W, data words beyond DATA_W and indices 8 to 15 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_valid_i | input | 1 | Register access this cycle |
| reg_write_i | input | 1 | 1 for write, 0 for read |
| reg_idx_i | input | 4 | Register index |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational from the index |
| bus_req_o | output | 1 | Bus request, held until granted |
| bus_gnt_i | input | 1 | Bus grant |
| bus_we_o | output | 1 | Bus write enable |
| bus_addr_o | output | ADDR_W | Bus address |
| bus_size_o | output | 3 | Bus access size code |
| bus_wdata_o | output | DATA_W | Bus write data |
| bus_rsp_valid_i | input | 1 | Bus response valid |
| bus_rsp_err_i | input | 1 | Bus response error |
| bus_rsp_rdata_i | input | DATA_W | Bus read data |

## Verification
The bench targets the collisions between register access and the bus in flight:
- An address write during a pending access must be refused. A design that accepted it would send the streaming pointer astray.
- A bus error that arrives while a busy error is already latched must not overwrite the first code. Otherwise the debugger would lose the original cause.
- A stale read must neither step the address nor start a bus access. A design that stepped it anyway would skip memory words silently.
- Data stored while an error is set must be discarded. Keeping it would change what the next bus write sends.

The bench also steps the address with auto-increment on writes and on auto-reads, and checks that the pre-increment and post-increment ordering differ. It tries sizes beyond the data width and expects no bus traffic for them.

// File: rtl/sba_pkg.sv
package sba_pkg;
  localparam logic [3:0] IDX_CTRL  = 4'd0;
  localparam logic [3:0] IDX_ADDR0 = 4'd1;
  localparam logic [3:0] IDX_ADDR2 = 4'd3;
  localparam logic [3:0] IDX_DATA0 = 4'd4;
  localparam logic [3:0] IDX_DATA3 = 4'd7;

  localparam int unsigned CTL_AINC  = 3;
  localparam int unsigned CTL_AREAD = 4;
  localparam int unsigned CTL_ERR   = 8;
  localparam int unsigned CTL_BUSY  = 12;
  localparam int unsigned CTL_STALE = 16;

  typedef enum logic [2:0] {
    ERR_NONE = 3'd0,
    ERR_BUS  = 3'd2,
    ERR_SIZE = 3'd3,
    ERR_BUSY = 3'd4
  } err_e;

  typedef struct packed {
    logic [2:0] size;
    logic       ainc;
    logic       aread;
  } ctl_t;
endpackage

// File: rtl/sba_size_dec.sv
module sba_size_dec #(
  parameter int unsigned ADDR_W = 64,
  parameter int unsigned DATA_W = 64
) (
  input  logic [2:0]        size_i,
  output logic              ok_o,
  output logic [ADDR_W-1:0] step_o
);
  localparam int unsigned MAX_SIZE = $clog2(DATA_W / 8);

  assign ok_o   = (32'(size_i) <= MAX_SIZE);
  assign step_o = ADDR_W'(1) << size_i;
endmodule

// File: rtl/sba_err_track.sv
module sba_err_track (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       set_i,
  input  logic [2:0] code_i,
  input  logic       clr_i,
  input  logic [2:0] clr_mask_i,
  output logic [2:0] err_o
);
  logic [2:0] err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     err_q <= 3'd0;
    else if (set_i && err_q == 3'd0) err_q <= code_i;
    else if (clr_i)                  err_q <= err_q & ~clr_mask_i;
  end

  assign err_o = err_q;

  assert_err_sticky_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_q != 3'd0 && !clr_i) |=> err_q == $past(err_q));

  assert_err_code_nonzero_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |-> code_i != 3'd0);
endmodule

// File: rtl/sba_bus_seq.sv
module sba_bus_seq #(
  parameter int unsigned ADDR_W = 64,
  parameter int unsigned DATA_W = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              issue_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [2:0]        size_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              bus_req_o,
  input  logic              bus_gnt_i,
  output logic              bus_we_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [2:0]        bus_size_o,
  output logic [DATA_W-1:0] bus_wdata_o,
  input  logic              bus_rsp_valid_i,
  input  logic              bus_rsp_err_i,
  output logic              busy_o,
  output logic              rd_ok_o,
  output logic              bus_err_o
);
  logic              req_q, busy_q, we_q;
  logic [ADDR_W-1:0] addr_q;
  logic [2:0]        size_q;
  logic [DATA_W-1:0] wdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q  <= 1'b0;
      busy_q <= 1'b0;
    end else begin
      if (issue_i)        req_q <= 1'b1;
      else if (bus_gnt_i) req_q <= 1'b0;
      if (issue_i)                       busy_q <= 1'b1;
      else if (busy_q && bus_rsp_valid_i) busy_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_q    <= 1'b0;
      addr_q  <= '0;
      size_q  <= 3'd0;
      wdata_q <= '0;
    end else if (issue_i) begin
      we_q    <= we_i;
      addr_q  <= addr_i;
      size_q  <= size_i;
      wdata_q <= wdata_i;
    end
  end

  assign bus_req_o   = req_q;
  assign bus_we_o    = we_q;
  assign bus_addr_o  = addr_q;
  assign bus_size_o  = size_q;
  assign bus_wdata_o = wdata_q;
  assign busy_o      = busy_q;
  assign rd_ok_o     = busy_q & bus_rsp_valid_i & ~bus_rsp_err_i & ~we_q;
  assign bus_err_o   = busy_q & bus_rsp_valid_i & bus_rsp_err_i;

  assert_req_within_busy_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o |-> busy_o);

  assert_req_held_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && !bus_gnt_i) |=> (bus_req_o && $stable(bus_addr_o) && $stable(bus_we_o)));

  assert_no_issue_when_busy_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_i |-> !busy_q);
endmodule

// File: rtl/sba_master.sv
module sba_master #(
  parameter int unsigned ADDR_W = 64,
  parameter int unsigned DATA_W = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_valid_i,
  input  logic              reg_write_i,
  input  logic [3:0]        reg_idx_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic              bus_req_o,
  input  logic              bus_gnt_i,
  output logic              bus_we_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [2:0]        bus_size_o,
  output logic [DATA_W-1:0] bus_wdata_o,
  input  logic              bus_rsp_valid_i,
  input  logic              bus_rsp_err_i,
  input  logic [DATA_W-1:0] bus_rsp_rdata_i
);
  import sba_pkg::*;

  localparam int unsigned NUM_AW   = ADDR_W / 32;
  localparam int unsigned NUM_DW   = DATA_W / 32;
  localparam int unsigned MAX_SIZE = $clog2(DATA_W / 8);

  ctl_t              ctl_q;
  logic              stale_q;
  logic [31:0]       addr_w [NUM_AW];
  logic [31:0]       data_w [NUM_DW];
  logic [ADDR_W-1:0] addr_q, inc_addr, step;
  logic [DATA_W-1:0] data_q, issue_wdata;

  logic       busy, rd_ok, bus_err, size_ok;
  logic [2:0] err;

  // address and data word views
  always_comb begin
    for (int k = 0; k < NUM_AW; k++) addr_q[32*k +: 32] = addr_w[k];
    for (int k = 0; k < NUM_DW; k++) data_q[32*k +: 32] = data_w[k];
  end

  // access decode
  logic       acc_wr, acc_rd, hit_ctrl, hit_addr, hit_data, data_ok, d0;
  logic [1:0] aw_sel, dw_sel;

  assign acc_wr   = reg_valid_i & reg_write_i;
  assign acc_rd   = reg_valid_i & ~reg_write_i;
  assign hit_ctrl = (reg_idx_i == IDX_CTRL);
  assign hit_addr = (reg_idx_i >= IDX_ADDR0) && (reg_idx_i <= IDX_ADDR2);
  assign hit_data = (reg_idx_i >= IDX_DATA0) && (reg_idx_i <= IDX_DATA3);
  assign aw_sel   = reg_idx_i[1:0] - 2'd1;
  assign dw_sel   = reg_idx_i[1:0];
  assign data_ok  = hit_data & (err == ERR_NONE);
  assign d0       = data_ok & (dw_sel == 2'd0);

  logic viol_busy, viol_stale, viol_size, d0_wr_go, d0_rd_go, start, issue, do_inc;
  logic err_set, ctl_wr_ok;
  logic [2:0] err_code;

  assign viol_busy  = busy & ((acc_wr & (hit_ctrl | hit_addr | data_ok)) | (acc_rd & d0));
  assign viol_stale = acc_rd & d0 & ~busy & stale_q;
  assign d0_wr_go   = acc_wr & d0 & ~busy;
  assign d0_rd_go   = acc_rd & d0 & ~busy & ~stale_q;
  assign start      = d0_wr_go | (d0_rd_go & ctl_q.aread);
  assign viol_size  = start & ~size_ok;
  assign issue      = start & size_ok;
  assign do_inc     = ctl_q.ainc & size_ok & (d0_wr_go | d0_rd_go);
  assign inc_addr   = addr_q + step;
  assign ctl_wr_ok  = acc_wr & hit_ctrl & ~busy;

  assign err_set  = bus_err | viol_busy | viol_stale | viol_size;
  assign err_code = bus_err ? ERR_BUS : (viol_size ? ERR_SIZE : ERR_BUSY);

  always_comb begin
    issue_wdata        = data_q;
    issue_wdata[31:0]  = reg_wdata_i;
  end

  sba_size_dec #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_size (
    .size_i (ctl_q.size),
    .ok_o   (size_ok),
    .step_o (step)
  );

  sba_err_track u_err (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .set_i      (err_set),
    .code_i     (err_code),
    .clr_i      (ctl_wr_ok),
    .clr_mask_i (reg_wdata_i[CTL_ERR +: 3]),
    .err_o      (err)
  );

  sba_bus_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bus (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .issue_i         (issue),
    .we_i            (d0_wr_go),
    .addr_i          ((d0_rd_go && ctl_q.ainc) ? inc_addr : addr_q),
    .size_i          (ctl_q.size),
    .wdata_i         (issue_wdata),
    .bus_req_o       (bus_req_o),
    .bus_gnt_i       (bus_gnt_i),
    .bus_we_o        (bus_we_o),
    .bus_addr_o      (bus_addr_o),
    .bus_size_o      (bus_size_o),
    .bus_wdata_o     (bus_wdata_o),
    .bus_rsp_valid_i (bus_rsp_valid_i),
    .bus_rsp_err_i   (bus_rsp_err_i),
    .busy_o          (busy),
    .rd_ok_o         (rd_ok),
    .bus_err_o       (bus_err)
  );

  // control and stale flag
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q   <= '{size: 3'd2, ainc: 1'b0, aread: 1'b0};
      stale_q <= 1'b0;
    end else begin
      if (ctl_wr_ok) begin
        ctl_q.size  <= reg_wdata_i[2:0];
        ctl_q.ainc  <= reg_wdata_i[CTL_AINC];
        ctl_q.aread <= reg_wdata_i[CTL_AREAD];
      end
      if (rd_ok || d0_wr_go) stale_q <= 1'b0;
      else if (d0_rd_go)     stale_q <= 1'b1;
    end
  end

  // address words
  for (genvar k = 0; k < NUM_AW; k++) begin : g_addr
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        addr_w[k] <= 32'd0;
      else if (do_inc)
        addr_w[k] <= inc_addr[32*k +: 32];
      else if (acc_wr && hit_addr && !busy && aw_sel == 2'(k))
        addr_w[k] <= reg_wdata_i;
    end
  end

  // data words
  for (genvar k = 0; k < NUM_DW; k++) begin : g_data
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        data_w[k] <= 32'd0;
      else if (rd_ok)
        data_w[k] <= bus_rsp_rdata_i[32*k +: 32];
      else if (acc_wr && data_ok && !busy && dw_sel == 2'(k))
        data_w[k] <= reg_wdata_i;
    end
  end

  // read mux
  always_comb begin
    reg_rdata_o = 32'd0;
    if (hit_ctrl) begin
      reg_rdata_o[2:0]           = ctl_q.size;
      reg_rdata_o[CTL_AINC]      = ctl_q.ainc;
      reg_rdata_o[CTL_AREAD]     = ctl_q.aread;
      reg_rdata_o[CTL_ERR +: 3]  = err;
      reg_rdata_o[CTL_BUSY]      = busy;
      reg_rdata_o[CTL_STALE]     = stale_q;
    end else if (hit_addr) begin
      for (int k = 0; k < NUM_AW; k++)
        if (aw_sel == 2'(k)) reg_rdata_o = addr_w[k];
    end else if (hit_data) begin
      for (int k = 0; k < NUM_DW; k++)
        if (dw_sel == 2'(k)) reg_rdata_o = data_w[k];
    end
  end

  assert_no_issue_with_error_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bus_req_o) |-> $past(err) == ERR_NONE);

  assert_size_legal_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o |-> (32'(bus_size_o) <= MAX_SIZE));

  assert_bus_err_keeps_data_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_err |=> $stable(data_q));

  assert_read_clears_stale_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_ok |=> !stale_q);
endmodule

// File: tb/sba_master_tb_top.sv
module sba_master_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_valid_i = 1'b0, reg_write_i = 1'b0;
  logic [3:0]  reg_idx_i = 4'd0;
  logic [31:0] reg_wdata_i = 32'd0;
  logic [31:0] reg_rdata_o;
  logic        bus_req_o, bus_we_o;
  logic        bus_gnt_i = 1'b0, bus_rsp_valid_i = 1'b0, bus_rsp_err_i = 1'b0;
  logic [63:0] bus_addr_o, bus_wdata_o;
  logic [63:0] bus_rsp_rdata_i = 64'd0;
  logic [2:0]  bus_size_o;

  always #2 clk_i = ~clk_i;

  sba_master #(.ADDR_W(64), .DATA_W(64)) dut_i (.*);

  int    n_chk = 0, n_fail = 0;
  bit    done = 1'b0;
  string cur_req = "R1";

  // reference model state
  logic [2:0]  m_size = 3'd2, m_err = 3'd0, m_bsize = 3'd0;
  logic        m_ainc = 0, m_aread = 0, m_stale = 0, m_busy = 0, m_req = 0, m_we = 0;
  logic [63:0] m_addr = 0, m_data = 0, m_baddr = 0, m_bwdata = 0;

  task automatic check(input string r, input logic [63:0] act, input logic [63:0] exp, input string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", r, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mdl_rdata(input logic [3:0] idx);
    logic [31:0] r = 32'd0;
    case (idx)
      4'd0: begin
        r[2:0] = m_size; r[3] = m_ainc; r[4] = m_aread;
        r[10:8] = m_err; r[12] = m_busy; r[16] = m_stale;
      end
      4'd1: r = m_addr[31:0];
      4'd2: r = m_addr[63:32];
      4'd4: r = m_data[31:0];
      4'd5: r = m_data[63:32];
      default: r = 32'd0;
    endcase
    return r;
  endfunction

  task automatic mdl_step(input logic v, input logic w, input logic [3:0] idx, input logic [31:0] wd,
                          input logic g, input logic rv, input logic re, input logic [63:0] rd);
    logic        ob = m_busy;
    logic [2:0]  oe = m_err;
    logic [2:0]  bcode = 3'd0, acc = 3'd0, nc;
    logic        ok = (m_size <= 3'd3);
    logic [63:0] inc = m_addr + (64'd1 << m_size);
    logic        iss = 0, iwe = 0;
    logic [63:0] iaddr = 0, iwd = 0;
    if (m_req && g) m_req = 0;
    if (ob && rv) begin
      m_busy = 0;
      if (re) bcode = 3'd2;
      else if (!m_we) begin m_data = rd; m_stale = 0; end
    end
    if (v) begin
      if (idx == 4'd0 && w) begin
        if (ob) acc = 3'd4;
        else begin
          m_size = wd[2:0]; m_ainc = wd[3]; m_aread = wd[4];
          m_err = oe & ~wd[10:8];
        end
      end else if (idx >= 4'd1 && idx <= 4'd3 && w) begin
        if (ob) acc = 3'd4;
        else if (idx == 4'd1) m_addr[31:0] = wd;
        else if (idx == 4'd2) m_addr[63:32] = wd;
      end else if (idx >= 4'd4 && idx <= 4'd7 && oe == 3'd0) begin
        if (w) begin
          if (ob) acc = 3'd4;
          else begin
            if (idx == 4'd4) m_data[31:0] = wd;
            if (idx == 4'd5) m_data[63:32] = wd;
            if (idx == 4'd4) begin
              m_stale = 0;
              if (!ok) acc = 3'd3;
              else begin
                iss = 1; iwe = 1; iaddr = m_addr; iwd = m_data;
                if (m_ainc) m_addr = inc;
              end
            end
          end
        end else if (idx == 4'd4) begin
          if (ob || m_stale) acc = 3'd4;
          else begin
            m_stale = 1;
            if (ok) begin
              if (m_ainc) m_addr = inc;
              if (m_aread) begin iss = 1; iwe = 0; iaddr = m_addr; end
            end else if (m_aread) acc = 3'd3;
          end
        end
      end
    end
    nc = (bcode != 3'd0) ? bcode : acc;
    if (nc != 3'd0 && oe == 3'd0) m_err = nc;
    if (iss) begin
      m_req = 1; m_busy = 1; m_we = iwe; m_baddr = iaddr; m_bsize = m_size; m_bwdata = iwd;
    end
  endtask

  task automatic cmp_bus();
    check(cur_req, 64'(bus_req_o), 64'(m_req), "bus_req");
    if (m_req) begin
      check(cur_req, bus_addr_o, m_baddr, "bus_addr");
      check(cur_req, 64'(bus_we_o), 64'(m_we), "bus_we");
      check(cur_req, 64'(bus_size_o), 64'(m_bsize), "bus_size");
      if (m_we) check(cur_req, bus_wdata_o, m_bwdata, "bus_wdata");
    end
  endtask

  // one clock: drive at negedge, compare read data, model step at posedge, compare bus
  task automatic cyc(input logic v, input logic w, input logic [3:0] idx, input logic [31:0] wd,
                     input logic g, input logic rv, input logic re, input logic [63:0] rd,
                     input logic lit, input logic [31:0] lit_val);
    reg_valid_i = v; reg_write_i = w; reg_idx_i = idx; reg_wdata_i = wd;
    bus_gnt_i = g; bus_rsp_valid_i = rv; bus_rsp_err_i = re; bus_rsp_rdata_i = rd;
    #1;
    check(cur_req, 64'(reg_rdata_o), 64'(mdl_rdata(idx)), "rdata vs model");
    if (lit) check(cur_req, 64'(reg_rdata_o), 64'(lit_val), "rdata literal");
    @(posedge clk_i);
    mdl_step(v, w, idx, wd, g, rv, re, rd);
    @(negedge clk_i);
    cmp_bus();
  endtask

  task automatic wr(input logic [3:0] idx, input logic [31:0] d);
    cyc(1, 1, idx, d, 0, 0, 0, 64'd0, 0, 32'd0);
  endtask
  task automatic rd(input logic [3:0] idx);
    cyc(1, 0, idx, 32'd0, 0, 0, 0, 64'd0, 0, 32'd0);
  endtask
  task automatic rdx(input logic [3:0] idx, input logic [31:0] e);
    cyc(1, 0, idx, 32'd0, 0, 0, 0, 64'd0, 1, e);
  endtask
  task automatic idle();
    cyc(0, 0, 4'd0, 32'd0, 0, 0, 0, 64'd0, 0, 32'd0);
  endtask
  task automatic serve(input logic err, input logic [63:0] data, input int dly);
    for (int i = 0; i < dly; i++) idle();
    cyc(0, 0, 4'd0, 32'd0, 1, 0, 0, 64'd0, 0, 32'd0);
    cyc(0, 0, 4'd0, 32'd0, 0, 1, err, data, 0, 32'd0);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (5000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL R1 watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    cur_req = "R1";
    idle();
    rdx(4'd0, 32'h0000_0002);
    rdx(4'd4, 32'd0);

    cur_req = "R13";
    wr(4'd1, 32'h0000_1000);
    wr(4'd2, 32'h0000_0001);
    rdx(4'd1, 32'h0000_1000);
    rdx(4'd2, 32'h0000_0001);
    rdx(4'd3, 32'd0);
    rdx(4'd9, 32'd0);

    cur_req = "R12";
    wr(4'd5, 32'hAABB_CCDD);
    rdx(4'd5, 32'hAABB_CCDD);

    cur_req = "R2";
    wr(4'd4, 32'h1122_3344);
    rdx(4'd0, 32'h0000_1002);
    serve(1'b0, 64'd0, 2);
    rdx(4'd0, 32'h0000_0002);

    cur_req = "R3";
    wr(4'd0, 32'h0000_000B);
    wr(4'd4, 32'h0000_0055);
    serve(1'b0, 64'd0, 0);
    rdx(4'd1, 32'h0000_1008);

    cur_req = "R9";
    wr(4'd4, 32'h0000_0066);
    wr(4'd1, 32'h0000_2000);
    rdx(4'd1, 32'h0000_1010);
    wr(4'd0, 32'h0000_0000);
    serve(1'b0, 64'd0, 1);
    rdx(4'd0, 32'h0000_040B);
    cur_req = "R11";
    wr(4'd0, 32'h0000_070B);
    rdx(4'd0, 32'h0000_000B);

    cur_req = "R4";
    wr(4'd0, 32'h0000_001B);
    rdx(4'd4, 32'h0000_0066);
    rdx(4'd0, 32'h0001_101B);
    cur_req = "R6";
    serve(1'b0, 64'hDEAD_BEEF_0123_4567, 1);
    rdx(4'd5, 32'hDEAD_BEEF);
    rdx(4'd0, 32'h0000_001B);

    cur_req = "R5";
    rdx(4'd4, 32'h0123_4567);
    rd(4'd4);
    serve(1'b0, 64'h0000_0002_0000_0001, 0);
    rdx(4'd0, 32'h0000_041B);
    wr(4'd0, 32'h0000_070B);
    rd(4'd4);
    rd(4'd4);
    rdx(4'd1, 32'h0000_1028);
    rdx(4'd0, 32'h0001_040B);
    wr(4'd0, 32'h0000_0703);

    cur_req = "R11";
    wr(4'd4, 32'h0000_0077);
    wr(4'd2, 32'h0000_0005);
    serve(1'b1, 64'd0, 0);
    rdx(4'd0, 32'h0000_0403);
    rdx(4'd2, 32'h0000_0001);
    wr(4'd0, 32'h0000_0703);

    cur_req = "R7";
    wr(4'd4, 32'h0000_0088);
    serve(1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 0);
    rdx(4'd0, 32'h0000_0203);
    rdx(4'd4, 32'h0000_0088);

    cur_req = "R10";
    wr(4'd4, 32'h0000_0099);
    rdx(4'd4, 32'h0000_0088);
    wr(4'd5, 32'h0000_0012);
    rdx(4'd5, 32'h0000_0002);
    rdx(4'd0, 32'h0000_0203);
    wr(4'd0, 32'h0000_0703);

    cur_req = "R8";
    wr(4'd0, 32'h0000_0004);
    wr(4'd4, 32'h0000_00AA);
    rdx(4'd0, 32'h0000_0304);
    wr(4'd0, 32'h0000_0703);
    wr(4'd4, 32'h0000_00BB);
    serve(1'b0, 64'd0, 0);
    wr(4'd0, 32'h0000_0016);
    rd(4'd4);
    rdx(4'd0, 32'h0001_0316);
    idle();

    done = 1'b1;
    summary();
    $finish;
  end
endmodule